// File: doc/BRIEF.md
# Three-Multiplier Complex Equalizer FIR

This block filters a complex baseband stream with a sixteen-tap equalizer whose taps are arbitrary complex values. No relation between taps is assumed. The datapath clock runs four times faster than the sample rate. Four lanes each form one complex product per clock, so every sample is finished after four phases. Each lane uses three real multipliers instead of four, which gives twelve real multipliers for the whole filter.

A complex product x·h is built from three real terms. The first is k1 = hr·(xr + xi), and it is shared by both output parts. The second is k2 = xr·(hi − hr). The third is k3 = xi·(hr + hi). The real result is k1 − k3 and the imaginary result is k1 + k2. The two coefficient-side terms (hr + hi) and (hi − hr) are formed once, when a tap is written, and are stored one bit wider next to hr. The data-side sum (xr + xi) is formed once, when a sample enters the history. Accumulation is exact. At the end the sum is scaled, rounded and clamped back to the input width.

The block is used by writing the taps while it is idle. Samples are then presented at most once per four clocks, and one result comes out for each accepted sample after a fixed delay.

Top module: `ceq_fir3m`

## Requirements
- R1: While reset is held, and after it is released, out_valid is 0 and out_re/out_im are 0 until a result is produced. All taps and all history entries start at zero, so the first result after reset is 0+0j.
- R2: For each accepted sample n, the result is y[n] = Σ_{k=0..15} h[k]·x[n−k] as an exact complex product sum. Tap address k multiplies the sample accepted k samples earlier, so address 0 is the newest sample.
- R3: Taps are signed Q1.15 and samples are signed 16-bit. Each part of the exact sum is divided by 2^15 with rounding half toward +∞, which means adding 2^14 and then shifting right arithmetically by 15.
- R4: Each rounded part is clamped to the range [−32768, 32767].
- R5: out_valid is a single-cycle pulse. It rises on the fifth rising edge after the edge that accepted the matching sample. Exactly one result is produced per accepted sample, and results keep input order.
- R6: A sample is accepted when the block is idle, or on the fourth edge after the previous acceptance. A sample presented one to three edges after an acceptance is dropped: it produces no result and never enters the history.
- R7: out_re and out_im hold their value in every cycle where out_valid is 0.
- R8: A tap written with coef_we while idle takes effect for every sample accepted afterwards. Rewriting a tap replaces its previous value.
- R9: The sample history is kept across idle gaps of any length. Later results still include samples accepted before the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, four times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_re | input | DATA_W | Sample real part, signed |
| in_im | input | DATA_W | Sample imaginary part, signed |
| coef_we | input | 1 | Tap write strobe |
| coef_addr | input | clog2(NTAPS) | Tap index (0 = newest sample) |
| coef_re | input | COEF_W | Tap real part, signed Q1.15 |
| coef_im | input | COEF_W | Tap imaginary part, signed Q1.15 |
| out_valid | output | 1 | Result strobe |
| out_re | output | DATA_W | Result real part, signed |
| out_im | output | DATA_W | Result imaginary part, signed |

## Verification
The bench builds the block with the default parameters: 16-bit samples and taps, 15 fraction bits, sixteen taps spread over four lanes. This yields four phases per sample. Each lane then walks every tap slot, so back-to-back samples exercise the sample accepted on the final phase, and offsets of one, two and three clocks exercise the drop rule. Full-scale taps and samples, including −32768 on both sides, push the exact sums far enough past the 16-bit range to reach both clamp limits. A single-LSB tap exposes rounding ties on either side of zero.

// File: rtl/ceq_pkg.sv
`timescale 1ns / 1ps
package ceq_pkg;
    // Sequencer states: waiting for a sample, or walking the tap phases.
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } ceq_state_e;
endpackage

// File: rtl/ceq_history.sv
`timescale 1ns / 1ps
// Sample history: newest sample at index 0. The data-side sum (re + im)
// is formed once on entry and kept next to the sample.
module ceq_history #(
    parameter int NTAPS = 16,
    parameter int DW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din_re,
    input  logic signed [DW-1:0] din_im,
    output logic signed [DW-1:0] h_re  [NTAPS],
    output logic signed [DW-1:0] h_im  [NTAPS],
    output logic signed [DW:0]   h_sum [NTAPS]
);
    localparam int SW = DW + 1;

    logic signed [SW-1:0] entry_sum;
    assign entry_sum = SW'(din_re) + SW'(din_im);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) begin
                h_re[k]  <= '0;
                h_im[k]  <= '0;
                h_sum[k] <= '0;
            end
        end else if (shift_en) begin
            h_re[0]  <= din_re;
            h_im[0]  <= din_im;
            h_sum[0] <= entry_sum;
            for (int k = 1; k < NTAPS; k++) begin
                h_re[k]  <= h_re[k-1];
                h_im[k]  <= h_im[k-1];
                h_sum[k] <= h_sum[k-1];
            end
        end
    end
endmodule

// File: rtl/ceq_coef_bank.sv
`timescale 1ns / 1ps
// Tap store. On a write, the real part is kept together with the
// precomputed (re + im) and (im - re) terms, each one bit wider.
module ceq_coef_bank #(
    parameter int NTAPS = 16,
    parameter int CW    = 16,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_re,
    input  logic signed [CW-1:0] wr_im,
    output logic signed [CW-1:0] t_re  [NTAPS],
    output logic signed [CW:0]   t_sum [NTAPS],
    output logic signed [CW:0]   t_dif [NTAPS]
);
    localparam int SW = CW + 1;

    logic signed [SW-1:0] w_sum;
    logic signed [SW-1:0] w_dif;
    assign w_sum = SW'(wr_re) + SW'(wr_im);
    assign w_dif = SW'(wr_im) - SW'(wr_re);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) begin
                t_re[k]  <= '0;
                t_sum[k] <= '0;
                t_dif[k] <= '0;
            end
        end else if (wr_en && (int'(wr_addr) < NTAPS)) begin
            t_re[wr_addr]  <= wr_re;
            t_sum[wr_addr] <= w_sum;
            t_dif[wr_addr] <= w_dif;
        end
    end
endmodule

// File: rtl/ceq_lane.sv
`timescale 1ns / 1ps
// One complex MAC lane built from three real multipliers.
//   k1 = hr*(xr+xi)   shared by both parts
//   k2 = xr*(hi-hr)
//   k3 = xi*(hr+hi)
//   re = k1 - k3,  im = k1 + k2
module ceq_lane #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 38
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic                    last,
    input  logic signed [DW-1:0]    x_re,
    input  logic signed [DW-1:0]    x_im,
    input  logic signed [DW:0]      x_sum,
    input  logic signed [CW-1:0]    c_re,
    input  logic signed [CW:0]      c_sum,
    input  logic signed [CW:0]      c_dif,
    output logic signed [ACC_W-1:0] part_re,
    output logic signed [ACC_W-1:0] part_im
);
    localparam int PROD_W = DW + CW + 1;
    localparam int TERM_W = PROD_W + 1;

    logic signed [PROD_W-1:0] k1, k2, k3;
    logic signed [TERM_W-1:0] term_re, term_im;
    logic signed [ACC_W-1:0]  acc_re_q, acc_im_q;
    logic signed [ACC_W-1:0]  acc_re_d, acc_im_d;

    assign k1 = PROD_W'(c_re) * PROD_W'(x_sum);
    assign k2 = PROD_W'(x_re) * PROD_W'(c_dif);
    assign k3 = PROD_W'(x_im) * PROD_W'(c_sum);

    assign term_re = TERM_W'(k1) - TERM_W'(k3);
    assign term_im = TERM_W'(k1) + TERM_W'(k2);

    always_comb begin
        if (first) begin
            acc_re_d = ACC_W'(term_re);
            acc_im_d = ACC_W'(term_im);
        end else begin
            acc_re_d = acc_re_q + ACC_W'(term_re);
            acc_im_d = acc_im_q + ACC_W'(term_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
            part_re  <= '0;
            part_im  <= '0;
        end else if (en) begin
            acc_re_q <= acc_re_d;
            acc_im_q <= acc_im_d;
            if (last) begin
                part_re <= acc_re_d;
                part_im <= acc_im_d;
            end
        end
    end
endmodule

// File: rtl/ceq_fir3m.sv
`timescale 1ns / 1ps
// Sixteen-tap complex equalizer, four lanes time-shared over four phases.
module ceq_fir3m #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 16,
    parameter int NLANES = 4,
    parameter int FRAC_W = COEF_W - 1,
    localparam int TAP_AW = $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic                     coef_we,
    input  logic [TAP_AW-1:0]        coef_addr,
    input  logic signed [COEF_W-1:0] coef_re,
    input  logic signed [COEF_W-1:0] coef_im,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    import ceq_pkg::*;

    localparam int NPHASE = NTAPS / NLANES;
    localparam int PH_W   = (NPHASE > 1) ? $clog2(NPHASE) : 1;
    localparam int PROD_W = DATA_W + COEF_W + 1;
    localparam int ACC_W  = PROD_W + 1 + TAP_AW;
    localparam int RW     = ACC_W + 1;
    localparam logic [PH_W-1:0]       PH_LAST = PH_W'(NPHASE - 1);
    localparam logic signed [RW-1:0]  RND_K   = RW'(1) <<< (FRAC_W - 1);
    localparam logic signed [RW-1:0]  SAT_HI  = RW'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [RW-1:0]  SAT_LO  = RW'(-(2 ** (DATA_W - 1)));

    // ---------------- sequencer ----------------
    ceq_state_e      state_q, state_d;
    logic [PH_W-1:0] phase_q, phase_d;
    logic            take;
    logic            run, first, last;
    logic            done_q;

    always_comb begin
        run   = (state_q == S_RUN);
        first = run && (phase_q == '0);
        last  = run && (phase_q == PH_LAST);
        take  = in_valid && ((state_q == S_IDLE) || last);
    end

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            S_IDLE: begin
                if (take) begin
                    state_d = S_RUN;
                    phase_d = '0;
                end
            end
            S_RUN: begin
                if (phase_q != PH_LAST) begin
                    phase_d = phase_q + PH_W'(1);
                end else if (take) begin
                    state_d = S_RUN;
                    phase_d = '0;
                end else begin
                    state_d = S_IDLE;
                    phase_d = '0;
                end
            end
            default: begin
                state_d = S_IDLE;
                phase_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // ---------------- storage ----------------
    logic signed [DATA_W-1:0] hist_re  [NTAPS];
    logic signed [DATA_W-1:0] hist_im  [NTAPS];
    logic signed [DATA_W:0]   hist_sum [NTAPS];
    logic signed [COEF_W-1:0] tap_re   [NTAPS];
    logic signed [COEF_W:0]   tap_sum  [NTAPS];
    logic signed [COEF_W:0]   tap_dif  [NTAPS];

    ceq_history #(
        .NTAPS (NTAPS),
        .DW    (DATA_W)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (take),
        .din_re   (in_re),
        .din_im   (in_im),
        .h_re     (hist_re),
        .h_im     (hist_im),
        .h_sum    (hist_sum)
    );

    ceq_coef_bank #(
        .NTAPS (NTAPS),
        .CW    (COEF_W),
        .AW    (TAP_AW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_re   (coef_re),
        .wr_im   (coef_im),
        .t_re    (tap_re),
        .t_sum   (tap_sum),
        .t_dif   (tap_dif)
    );

    // ---------------- lanes ----------------
    logic signed [ACC_W-1:0] lane_re [NLANES];
    logic signed [ACC_W-1:0] lane_im [NLANES];

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [TAP_AW-1:0] idx;
        assign idx = TAP_AW'(phase_q) * TAP_AW'(NLANES) + TAP_AW'(l);

        ceq_lane #(
            .DW    (DATA_W),
            .CW    (COEF_W),
            .ACC_W (ACC_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (run),
            .first   (first),
            .last    (last),
            .x_re    (hist_re[idx]),
            .x_im    (hist_im[idx]),
            .x_sum   (hist_sum[idx]),
            .c_re    (tap_re[idx]),
            .c_sum   (tap_sum[idx]),
            .c_dif   (tap_dif[idx]),
            .part_re (lane_re[l]),
            .part_im (lane_im[l])
        );
    end

    // ---------------- reduction, rounding, clamp ----------------
    logic signed [ACC_W-1:0] tot_re, tot_im;

    always_comb begin
        tot_re = '0;
        tot_im = '0;
        for (int l = 0; l < NLANES; l++) begin
            tot_re = tot_re + lane_re[l];
            tot_im = tot_im + lane_im[l];
        end
    end

    function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] v);
        logic signed [RW-1:0] r;
        r = RW'(v) + RND_K;
        r = r >>> FRAC_W;
        if (r > SAT_HI) begin
            return SAT_HI[DATA_W-1:0];
        end else if (r < SAT_LO) begin
            return SAT_LO[DATA_W-1:0];
        end
        return r[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            done_q    <= last;
            out_valid <= done_q;
            if (done_q) begin
                out_re <= rnd_sat(tot_re);
                out_im <= rnd_sat(tot_im);
            end
        end
    end
endmodule

// File: rtl/ceq_fir3m_chk.sv
`timescale 1ns / 1ps
module ceq_fir3m_chk #(
    parameter int DW     = 16,
    parameter int NPHASE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 take,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im
);
    localparam int LAT = 5;
    localparam int GW  = $clog2(NPHASE) + 1;

    logic [LAT:0]   acc_pipe;
    logic [GW-1:0]  since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_pipe <= '0;
            since_q  <= '1;
        end else begin
            acc_pipe <= {acc_pipe[LAT-1:0], take};
            if (take) begin
                since_q <= '0;
            end else if (since_q != '1) begin
                since_q <= since_q + GW'(1);
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_re == '0 && out_im == '0)); // R1

    AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == acc_pipe[LAT]); // R5

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5

    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (int'(since_q) >= NPHASE - 1)); // R6

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_re == $past(out_re) && out_im == $past(out_im))); // R7
endmodule

bind ceq_fir3m ceq_fir3m_chk #(
    .DW     (DATA_W),
    .NPHASE (NTAPS / NLANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/ceq_fir3m_bench.sv
`timescale 1ns / 1ps
module ceq_fir3m_bench;
    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int NT  = 16;
    localparam int AW  = 4;
    localparam int LAT = 5;
    localparam int SPACING = 4;

    typedef struct {
        int    re;
        int    im;
        int    cyc;
        string tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic signed [DW-1:0] in_re, in_im;
    logic                 coef_we;
    logic [AW-1:0]        coef_addr;
    logic signed [CW-1:0] coef_re, coef_im;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    always #2.5 clk = ~clk;

    ceq_fir3m u_ceq_fir3m (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_re   (coef_re),
        .coef_im   (coef_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   last_e = -100;
    int   drops = 0;
    int   hold_bad = 0;
    bit   seen = 0;
    int   last_re = 0, last_im = 0;
    logic [31:0] seed = 32'h1234_5678;
    int   m_cre [NT];
    int   m_cim [NT];
    int   m_xre [NT];
    int   m_xim [NT];
    exp_t exp_q[$];
    exp_t it;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint rsat(input longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcoef(input int a, input int re, input int im);
        coef_we   = 1'b1;
        coef_addr = AW'(a);
        coef_re   = CW'(re);
        coef_im   = CW'(im);
        m_cre[a]  = re;
        m_cim[a]  = im;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // Driver: presents one sample for one clock and models acceptance.
    task automatic send(input int re, input int im, input string tag);
        int     e;
        longint ar, ai;
        exp_t   x;
        e        = cyc + 1;
        in_valid = 1'b1;
        in_re    = DW'(re);
        in_im    = DW'(im);
        if (e - last_e >= SPACING) begin
            last_e = e;
            for (int k = NT - 1; k > 0; k--) begin
                m_xre[k] = m_xre[k-1];
                m_xim[k] = m_xim[k-1];
            end
            m_xre[0] = re;
            m_xim[0] = im;
            ar = 0;
            ai = 0;
            for (int k = 0; k < NT; k++) begin
                ar += longint'(m_cre[k]) * m_xre[k] - longint'(m_cim[k]) * m_xim[k];
                ai += longint'(m_cre[k]) * m_xim[k] + longint'(m_cim[k]) * m_xre[k];
            end
            x.re  = int'(rsat(ar));
            x.im  = int'(rsat(ai));
            x.cyc = e + LAT;
            x.tag = tag;
            exp_q.push_back(x);
        end else begin
            drops++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every result strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "result with nothing pending", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(cyc == it.cyc, "R5", "result cycle", cyc, it.cyc);
                    chk(int'(out_re) == it.re, it.tag, "real part", int'(out_re), it.re);
                    chk(int'(out_im) == it.im, it.tag, "imag part", int'(out_im), it.im);
                end
                last_re = int'(out_re);
                last_im = int'(out_im);
                seen    = 1'b1;
            end else if (seen && (int'(out_re) != last_re || int'(out_im) != last_im)) begin
                hold_bad++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_re     = '0;
        in_im     = '0;
        coef_we   = 1'b0;
        coef_addr = '0;
        coef_re   = '0;
        coef_im   = '0;
        for (int k = 0; k < NT; k++) begin
            m_cre[k] = 0; m_cim[k] = 0; m_xre[k] = 0; m_xim[k] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet outputs after reset, zero taps give zero result
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_re == '0, "R1", "out_re after reset", int'(out_re), 0);
        chk(out_im == '0, "R1", "out_im after reset", int'(out_im), 0);
        gap(1);
        send(1234, -999, "R1");
        gap(8);

        // R2: arbitrary taps, back-to-back samples on the final phase
        for (int k = 0; k < NT; k++) wcoef(k, rnd16(), rnd16());
        for (int n = 0; n < 40; n++) begin
            send(rnd16(), rnd16(), "R2");
            gap(SPACING - 1);
        end
        gap(8);

        // R9: long idle gaps keep the history
        for (int n = 0; n < 6; n++) begin
            send(rnd16(), rnd16(), "R9");
            gap(10 + n);
        end
        gap(4);

        // R6: samples one, two and three clocks after an acceptance are dropped
        send(rnd16(), rnd16(), "R6");
        gap(1);
        send(30000, -30000, "R6");
        gap(1);
        send(rnd16(), rnd16(), "R6");
        gap(2);
        send(-31000, 29000, "R6");
        send(rnd16(), rnd16(), "R6");
        send(25000, 25000, "R6");
        gap(2);
        send(rnd16(), rnd16(), "R6");
        gap(3);
        send(rnd16(), rnd16(), "R6");
        gap(8);
        chk(exp_q.size() == 0, "R6", "pending results after drops", exp_q.size(), 0);
        chk(drops == 3, "R6", "dropped sample count", drops, 3);

        // R3: single-LSB tap exposes rounding ties
        for (int k = 0; k < NT; k++) wcoef(k, 0, 0);
        wcoef(0, 1, 0);
        send(16384, 0, "R3");   gap(3);
        send(16383, 0, "R3");   gap(3);
        send(-16384, 0, "R3");  gap(3);
        send(-16385, 0, "R3");  gap(3);
        send(0, 16384, "R3");   gap(3);
        send(0, -16385, "R3");  gap(8);

        // R8: rewrite taps, including the oldest slot
        wcoef(0, 0, 1);
        wcoef(NT - 1, -32768, 0);
        for (int n = 0; n < 20; n++) begin
            send((n % 2 == 0) ? 16384 : rnd16(), rnd16(), "R8");
            gap(3);
        end
        gap(8);

        // R4: full-scale taps and samples drive both clamp limits
        for (int k = 0; k < NT; k++) wcoef(k, 32767, 32767);
        for (int n = 0; n < 16; n++) begin send(32767, 32767, "R4"); gap(3); end
        for (int n = 0; n < 16; n++) begin send(32767, -32768, "R4"); gap(3); end
        for (int n = 0; n < 16; n++) begin send(-32768, -32768, "R4"); gap(3); end
        gap(8);
        for (int k = 0; k < NT; k++) wcoef(k, -32768, 0);
        for (int n = 0; n < 16; n++) begin send(-32768, 32767, "R4"); gap(3); end
        gap(10);

        chk(exp_q.size() == 0, "R5", "results still pending at end", exp_q.size(), 0);
        chk(hold_bad == 0, "R7", "output changes without strobe", hold_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule